// File: doc/BRIEF.md
# Planar Graphics Controller Write Path

This block sits between a CPU byte bus and four 8-bit plane memories of a planar colour display adapter. The CPU sees one byte-wide memory window. Each byte address holds eight pixels, and each pixel has one bit in each of the four planes. The block also provides two small I/O register banks. Each bank is loaded by first writing an index and then writing a data byte. The first bank, the graphics bank, holds the drawing setup: a colour for forced plane fills, a per-plane enable for that colour, a rotate count with a logical operation, a plane selector for reads, a mode register and a per-pixel write mask. The second bank, the sequencer bank, holds the mask of planes that may be written.

A CPU memory read loads all four plane bytes at the address into four latches and returns one of them. A CPU memory write builds one byte per plane. That byte is either the rotated CPU byte or a solid fill from the colour register. It is then combined with the latched plane byte by the selected logical operation. Finally, the write mask merges it with the latch bit by bit, and the result is stored only in the enabled planes. A typical drawing sequence is: read the address to fill the latches, set the mask, then write. Only the pixels under the mask change.

Top module: `planar_gfx_wpath`

## Requirements
- R1: After synchronous reset the following registers read as zero: both index registers, the fill colour, the fill enable, the rotate register, the read plane select and the mode register. The write mask reads 0xFF and the plane write mask reads 0x0F.
- R2: `io_sel` picks the I/O port: 0 = graphics index, 1 = graphics data, 2 = sequencer index, 3 = sequencer data. The graphics index keeps the low 4 bits of the byte written to it. Data writes go to the indexed register: 0 = fill colour (bits 3:0), 1 = fill enable (bits 3:0), 3 = rotate register (bits 4:0), 4 = read plane select (bits 1:0), 5 = mode register (bits 1:0 and bit 3), 8 = write mask (bits 7:0). The index persists, so repeated data writes reach the same register. Bits outside these fields read back as zero.
- R3: A graphics data write while the index is 2, 6, 7 or 9–15 changes no register, and reading the data port at such an index returns 0.
- R4: The sequencer index keeps the low 3 bits of the byte written to it. At sequencer index 2, the data port holds the plane write mask in bits 3:0, where bit p enables writes to plane p. Other sequencer indices read as 0 and ignore writes.
- R5: A memory read loads all four plane bytes at `mem_addr` into the latches. `mem_rdata` then shows the latch of the plane chosen by read plane select, from the cycle after the read onward. It follows later changes of the select without a new read.
- R6: Rotate register bits 2:0 right-rotate the CPU write byte by that many positions.
- R7: When fill enable bit p is 1, plane p's source byte is 0xFF if fill colour bit p is 1, and 0x00 otherwise, whatever the CPU data.
- R8: Rotate register bits 4:3 select the operation applied between the source byte and the plane latch: 0 = source, 1 = AND, 2 = OR, 3 = XOR.
- R9: The stored byte takes the operation result where the write mask bit is 1 and the latch bit where it is 0.
- R10: A memory write stores into plane p only when plane write mask bit p is 1; the other planes keep their contents.
- R11: `io_rdata` is registered: one cycle after `io_sel` is applied it shows the selected index register or the indexed data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_we | input | 1 | I/O port write strobe |
| io_sel | input | 2 | I/O port select (0 gfx index, 1 gfx data, 2 seq index, 3 seq data) |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | Registered I/O read byte |
| mem_rd | input | 1 | CPU memory read strobe |
| mem_we | input | 1 | CPU memory write strobe |
| mem_addr | input | AW | CPU byte address within the planes |
| mem_wdata | input | 8 | CPU write byte |
| mem_rdata | output | 8 | Selected plane latch |

## Verification
Register updates take effect at the clock edge that samples the write. The registered I/O read data is due one edge after `io_sel` is applied, so the bench drives on the falling edge and samples at the next falling edge. A memory read fills the latches at its edge, so `mem_rdata` is compared at the falling edge that follows. A memory write is visible only through a later read, which always comes at least two edges after the write. Each datapath case first reloads the latches with a read before it sets up the mask or operation under test.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int PIX_W  = 8;
  localparam int PLANES = 4;

  typedef enum logic [1:0] {OP_PASS = 2'd0, OP_AND = 2'd1, OP_OR = 2'd2, OP_XOR = 2'd3} lop_e;

  typedef struct packed {
    logic [PLANES-1:0] fill_col;
    logic [PLANES-1:0] fill_en;
    logic [2:0]        rot;
    lop_e              op;
    logic [1:0]        rsel;
    logic [1:0]        wmode;
    logic              rmode;
    logic [PIX_W-1:0]  wmask;
    logic [PLANES-1:0] pmask;
  } pgw_cfg_t;

  localparam logic [3:0] GX_FILL  = 4'd0;
  localparam logic [3:0] GX_FEN   = 4'd1;
  localparam logic [3:0] GX_ROT   = 4'd3;
  localparam logic [3:0] GX_RSEL  = 4'd4;
  localparam logic [3:0] GX_MODE  = 4'd5;
  localparam logic [3:0] GX_WMASK = 4'd8;
  localparam logic [2:0] SX_PMASK = 3'd2;
endpackage

// File: rtl/pgw_regs.sv
module pgw_regs
  import pgw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             io_we,
  input  logic [1:0]       io_sel,
  input  logic [7:0]       io_wdata,
  output pgw_cfg_t         cfg,
  output logic [3:0]       gx_idx,
  output logic [7:0]       io_rdata
);
  logic [2:0] sx_idx;
  logic [7:0] gx_val, sx_val, rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      gx_idx    <= '0;
      sx_idx    <= '0;
      cfg       <= '0;
      cfg.wmask <= '1;
      cfg.pmask <= '1;
    end else if (io_we) begin
      case (io_sel)
        2'd0: gx_idx <= io_wdata[3:0];
        2'd1: begin
          case (gx_idx)
            GX_FILL:  cfg.fill_col <= io_wdata[PLANES-1:0];
            GX_FEN:   cfg.fill_en  <= io_wdata[PLANES-1:0];
            GX_ROT: begin
              cfg.rot <= io_wdata[2:0];
              cfg.op  <= lop_e'(io_wdata[4:3]);
            end
            GX_RSEL:  cfg.rsel <= io_wdata[1:0];
            GX_MODE: begin
              cfg.wmode <= io_wdata[1:0];
              cfg.rmode <= io_wdata[3];
            end
            GX_WMASK: cfg.wmask <= io_wdata;
            default: ;
          endcase
        end
        2'd2: sx_idx <= io_wdata[2:0];
        default: if (sx_idx == SX_PMASK) cfg.pmask <= io_wdata[PLANES-1:0];
      endcase
    end
  end

  always_comb begin
    case (gx_idx)
      GX_FILL:  gx_val = {{(8-PLANES){1'b0}}, cfg.fill_col};
      GX_FEN:   gx_val = {{(8-PLANES){1'b0}}, cfg.fill_en};
      GX_ROT:   gx_val = {3'b000, cfg.op, cfg.rot};
      GX_RSEL:  gx_val = {6'b0, cfg.rsel};
      GX_MODE:  gx_val = {4'b0, cfg.rmode, 1'b0, cfg.wmode};
      GX_WMASK: gx_val = cfg.wmask;
      default:  gx_val = 8'h00;
    endcase
    sx_val = (sx_idx == SX_PMASK) ? {{(8-PLANES){1'b0}}, cfg.pmask} : 8'h00;
    case (io_sel)
      2'd0:    rd_next = {4'b0, gx_idx};
      2'd1:    rd_next = gx_val;
      2'd2:    rd_next = {5'b0, sx_idx};
      default: rd_next = sx_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else     io_rdata <= rd_next;
  end
endmodule

// File: rtl/pgw_wcombine.sv
module pgw_wcombine
  import pgw_pkg::*;
(
  input  pgw_cfg_t                      cfg,
  input  logic [PIX_W-1:0]              cpu_data,
  input  logic [PLANES-1:0][PIX_W-1:0]  latch,
  output logic [PLANES-1:0][PIX_W-1:0]  wbyte
);
  logic [2*PIX_W-1:0] dbl;
  logic [PIX_W-1:0]   rot_d;

  always_comb begin
    dbl   = {cpu_data, cpu_data} >> cfg.rot;
    rot_d = dbl[PIX_W-1:0];
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [PIX_W-1:0] src, res;
    always_comb begin
      src = cfg.fill_en[p] ? {PIX_W{cfg.fill_col[p]}} : rot_d;
      case (cfg.op)
        OP_AND:  res = src & latch[p];
        OP_OR:   res = src | latch[p];
        OP_XOR:  res = src ^ latch[p];
        default: res = src;
      endcase
      wbyte[p] = (res & cfg.wmask) | (latch[p] & ~cfg.wmask);
    end
  end
endmodule

// File: rtl/pgw_plane_ram.sv
module pgw_plane_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/planar_gfx_wpath.sv
module planar_gfx_wpath
  import pgw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_we,
  input  logic [1:0]    io_sel,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic          mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_wdata,
  output logic [7:0]    mem_rdata
);
  pgw_cfg_t                     cfg;
  logic [3:0]                   gx_idx;
  logic [PLANES-1:0][PIX_W-1:0] latch;
  logic [PLANES-1:0][PIX_W-1:0] wbyte;
  logic [PLANES-1:0]            ram_we;

  pgw_regs u_regs (
    .clk(clk), .rst(rst), .io_we(io_we), .io_sel(io_sel), .io_wdata(io_wdata),
    .cfg(cfg), .gx_idx(gx_idx), .io_rdata(io_rdata)
  );

  pgw_wcombine u_comb (
    .cfg(cfg), .cpu_data(mem_wdata), .latch(latch), .wbyte(wbyte)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_ram
    assign ram_we[p] = mem_we & cfg.pmask[p];
    pgw_plane_ram #(.AW(AW), .DW(PIX_W)) u_ram (
      .clk(clk), .rst(rst), .we(ram_we[p]), .re(mem_rd),
      .addr(mem_addr), .wdata(wbyte[p]), .rdata(latch[p])
    );
  end

  assign mem_rdata = latch[cfg.rsel];
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk
  import pgw_pkg::*;
(
  input logic                         clk,
  input logic                         rst,
  input logic                         io_we,
  input logic [1:0]                   io_sel,
  input logic                         mem_rd,
  input logic                         mem_we,
  input pgw_cfg_t                     cfg,
  input logic [3:0]                   gx_idx,
  input logic [PLANES-1:0][PIX_W-1:0] latch,
  input logic [PLANES-1:0][PIX_W-1:0] wbyte,
  input logic [PLANES-1:0]            ram_we
);
  logic unimpl;
  assign unimpl = !(gx_idx inside {GX_FILL, GX_FEN, GX_ROT, GX_RSEL, GX_MODE, GX_WMASK});

  // R1
  reset_vals_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg.wmask == 8'hFF && cfg.pmask == 4'hF && cfg.fill_en == '0));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_we && io_sel == 2'd0) |=> $stable(gx_idx));

  // R3
  unimpl_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (io_we && io_sel == 2'd1 && unimpl) |=> $stable(cfg));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_rd |=> $stable(latch));

  // R9
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (((wbyte[0] ^ latch[0]) & ~cfg.wmask) == '0 &&
                ((wbyte[3] ^ latch[3]) & ~cfg.wmask) == '0));

  // R10
  plane_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we & ~cfg.pmask) == '0);
endmodule

bind planar_gfx_wpath pgw_chk i_pgw_chk (
  .clk(clk), .rst(rst), .io_we(io_we), .io_sel(io_sel), .mem_rd(mem_rd),
  .mem_we(mem_we), .cfg(cfg), .gx_idx(gx_idx), .latch(latch), .wbyte(wbyte),
  .ram_we(ram_we)
);

// File: tb/test_planar_gfx_wpath.sv
module test_planar_gfx_wpath;
  localparam int AW = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic io_we = 1'b0, mem_rd = 1'b0, mem_we = 1'b0;
  logic [1:0] io_sel = '0;
  logic [7:0] io_wdata = '0, mem_wdata = '0, io_rdata, mem_rdata;
  logic [AW-1:0] mem_addr = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  planar_gfx_wpath #(.AW(AW)) i_planar_gfx_wpath (
    .clk(clk), .rst(rst), .io_we(io_we), .io_sel(io_sel), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); io_we = 1'b1; io_sel = s; io_wdata = d;
    @(negedge clk); io_we = 1'b0;
  endtask

  task automatic io_rd(logic [1:0] s, output logic [7:0] v);
    @(negedge clk); io_we = 1'b0; io_sel = s;
    @(negedge clk); v = io_rdata;
  endtask

  task automatic gx_set(logic [7:0] i, logic [7:0] v);
    io_wr(2'd0, i); io_wr(2'd1, v);
  endtask

  task automatic gx_get(logic [7:0] i, output logic [7:0] v);
    io_wr(2'd0, i); io_rd(2'd1, v);
  endtask

  task automatic mwr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); mem_we = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk); mem_we = 1'b0;
  endtask

  task automatic mrd(logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); mem_rd = 1'b1; mem_addr = a;
    @(negedge clk); mem_rd = 1'b0; v = mem_rdata;
  endtask

  task automatic plane_rd(logic [AW-1:0] a, int p, output logic [7:0] v);
    gx_set(8'd4, 8'(p)); mrd(a, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    io_rd(2'd0, v); chk("R1 gx index", v, 8'h00);
    io_rd(2'd1, v); chk("R1 fill colour", v, 8'h00);
    gx_get(8'd1, v); chk("R1 fill enable", v, 8'h00);
    gx_get(8'd3, v); chk("R1 rotate", v, 8'h00);
    gx_get(8'd5, v); chk("R1 mode", v, 8'h00);
    gx_get(8'd8, v); chk("R1 write mask", v, 8'hFF);
    io_wr(2'd2, 8'd2); io_rd(2'd3, v); chk("R1 plane mask", v, 8'h0F);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    gx_set(8'd3, 8'hFF); io_rd(2'd1, v); chk("R2 rotate field", v, 8'h1F);
    gx_set(8'd5, 8'hFF); io_rd(2'd1, v); chk("R2 mode field", v, 8'h0B);
    gx_set(8'd4, 8'hFE); io_rd(2'd1, v); chk("R2 read select", v, 8'h02);
    gx_set(8'd8, 8'h3C); io_wr(2'd1, 8'hA5); io_rd(2'd1, v);
    chk("R2 index kept", v, 8'hA5);
    io_rd(2'd0, v); chk("R11 index readback", v, 8'h08);
    gx_set(8'd2, 8'h77); io_rd(2'd1, v); chk("R3 unimpl idx 2", v, 8'h00);
    gx_set(8'd9, 8'h12); gx_get(8'd8, v); chk("R3 mask untouched", v, 8'hA5);
    io_wr(2'd2, 8'd5); io_wr(2'd3, 8'h00); io_rd(2'd3, v); chk("R4 other seq idx", v, 8'h00);
    io_wr(2'd2, 8'd2); io_rd(2'd3, v); chk("R4 plane mask kept", v, 8'h0F);
    io_wr(2'd3, 8'hF6); io_rd(2'd3, v); chk("R4 plane mask write", v, 8'h06);
    gx_set(8'd3, 8'h00); gx_set(8'd5, 8'h00); gx_set(8'd4, 8'h00);
    gx_set(8'd8, 8'hFF); io_wr(2'd3, 8'h0F);
  endtask

  task automatic t_fill_planes();
    logic [7:0] v;
    for (int p = 0; p < 4; p++) begin
      io_wr(2'd2, 8'd2); io_wr(2'd3, 8'(1 << p)); mwr(8'd5, 8'(8'h11 * (p + 1)));
    end
    io_wr(2'd3, 8'h0F);
    mrd(8'd5, v); chk("R5 plane0", v, 8'h11);
    for (int p = 1; p < 4; p++) begin
      gx_set(8'd4, 8'(p)); @(negedge clk); chk("R5 select w/o read", mem_rdata, 8'(8'h11 * (p + 1)));
    end
    io_wr(2'd2, 8'd2); io_wr(2'd3, 8'h02); mwr(8'd5, 8'h77); io_wr(2'd3, 8'h0F);
    plane_rd(8'd5, 0, v); chk("R10 plane0 kept", v, 8'h11);
    plane_rd(8'd5, 1, v); chk("R10 plane1 written", v, 8'h77);
    plane_rd(8'd5, 3, v); chk("R10 plane3 kept", v, 8'h44);
  endtask

  task automatic t_rotate();
    logic [7:0] v;
    gx_set(8'd3, 8'h03); mwr(8'd9, 8'h81); gx_set(8'd3, 8'h00);
    plane_rd(8'd9, 2, v); chk("R6 rotate by 3", v, 8'h30);
  endtask

  task automatic t_setreset();
    logic [7:0] v;
    gx_set(8'd0, 8'h03); gx_set(8'd1, 8'h05); mwr(8'd10, 8'hAA);
    gx_set(8'd1, 8'h00);
    plane_rd(8'd10, 0, v); chk("R7 plane0 fill ones", v, 8'hFF);
    plane_rd(8'd10, 1, v); chk("R7 plane1 cpu data", v, 8'hAA);
    plane_rd(8'd10, 2, v); chk("R7 plane2 fill zeros", v, 8'h00);
  endtask

  task automatic op_case(logic [1:0] op, logic [7:0] exp);
    logic [7:0] v;
    gx_set(8'd3, 8'h00); mwr(8'd20, 8'hF0); mrd(8'd20, v);
    gx_set(8'd3, {3'b000, op, 3'b000}); mwr(8'd20, 8'h3C); gx_set(8'd3, 8'h00);
    plane_rd(8'd20, 3, v); chk("R8 logical op", v, exp);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    mwr(8'd30, 8'hF0); mrd(8'd30, v);
    gx_set(8'd8, 8'h0F); mwr(8'd30, 8'h55); gx_set(8'd8, 8'hFF);
    plane_rd(8'd30, 1, v); chk("R9 masked merge", v, 8'hF5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_fill_planes();
    t_rotate();
    t_setreset();
    op_case(2'd1, 8'h30);
    op_case(2'd2, 8'hFC);
    op_case(2'd3, 8'hCC);
    t_mask();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule